// File: doc/BRIEF.md
# Early Receive Overrun Detector

When a frame is received with early receive enabled, the host may begin copying frame data out of the shared buffer RAM before the receive DMA has finished writing that frame. This block watches both sides of the RAM and reports when the host-side reader has caught up with the writer. It keeps the address of the most recent DMA write. It compares every host-side read against that address at 32-bit word granularity.

A read that lands on the same word as the newest write means the reader may have fetched stale data. The block then raises a sticky failure flag. It also captures the local buffer address of that DMA write and exposes it as a low byte and a high byte. The host reads the flag and the address, recopies the frame from that point or earlier, and clears the flag. Detection is armed by a frame-start pulse and stops once the DMA reports the frame done.

Top module: `early_rx_overrun_det`

## Requirements
- R1: After reset the failure flag is 0, both capture bytes are 0x00, and detection is disarmed until the first frame_start pulse.
- R2: Each DMA write replaces the tracked address, so only the most recent write is compared. A DMA write in the same cycle as a read counts as the most recent write for that read.
- R3: A read matches when its address and the tracked address agree in every bit except the two lowest.
- R4: In a cycle with frame_done high, no read can match, and detection stays off from then until the next frame_start. A read in a frame_start cycle does not match either.
- R5: After frame_start, no read matches until the first DMA write of the new frame. A write in the frame_start cycle itself counts as that first write.
- R6: A match sets fail_flag in the next cycle. It also loads the full tracked write address into the capture: bits 7:0 go to cap_lo and bits 15:8 go to cap_hi. Address bits above ADDR_W read as zero.
- R7: While fail_flag is set and host_clr is low, the flag stays set and the capture does not change, even when further reads match.
- R8: host_clr without a match in the same cycle clears fail_flag and zeroes both capture bytes in the next cycle.
- R9: When host_clr and a match happen in the same cycle, the flag stays set and the capture takes the address of the new match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Pulse at the start of a received frame; arms detection |
| frame_done | input | 1 | Pulse when the DMA has finished storing the frame |
| dma_wr_en | input | 1 | DMA write strobe into buffer RAM |
| dma_wr_addr | input | ADDR_W | Local byte address of the DMA write |
| rd_en | input | 1 | Host-side reader strobe from buffer RAM |
| rd_addr | input | ADDR_W | Local byte address of the read |
| host_clr | input | 1 | Host clears the failure flag |
| fail_flag | output | 1 | Sticky early-receive failure flag |
| cap_lo | output | 8 | Captured write address, bits 7:0 |
| cap_hi | output | 8 | Captured write address, bits 15:8 |

## Verification
The main pattern places one DMA write at each byte of a 16-byte window and sweeps reads over a 32-byte span around it. Matches inside the same word and misses one byte across a word boundary show that the two low bits are dropped while every other bit still counts. Two-write sequences check that only the newest write is tracked, including one written in the same cycle as the read. Frame-start and frame-done orderings separate the armed window from the unarmed one. Repeated matches and clears that collide with a match show which of the two wins the capture.

// File: rtl/erod_pkg.sv
package erod_pkg;
  localparam int unsigned MAX_AW = 32;
  localparam int unsigned CAP_W  = 16;
  typedef logic [MAX_AW-1:0] wide_addr_t;

  function automatic logic same_word(input wide_addr_t a, input wide_addr_t b,
                                     input int unsigned drop_bits);
    return (a >> drop_bits) == (b >> drop_bits);
  endfunction

  function automatic logic [7:0] cap_byte(input logic [CAP_W-1:0] v, input int unsigned idx);
    return v[idx*8 +: 8];
  endfunction
endpackage

// File: rtl/erod_wr_track.sv
module erod_wr_track #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_done,
  input  logic              dma_wr_en,
  input  logic [ADDR_W-1:0] dma_wr_addr,
  output logic              cmp_en,
  output logic              eff_valid,
  output logic [ADDR_W-1:0] eff_addr
);
  logic              armed_q;
  logic              valid_q;
  logic [ADDR_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      valid_q <= 1'b0;
      last_q  <= '0;
    end else begin
      if (frame_start)     armed_q <= 1'b1;
      else if (frame_done) armed_q <= 1'b0;
      if (dma_wr_en) begin
        valid_q <= 1'b1;
        last_q  <= dma_wr_addr;
      end else if (frame_start) begin
        valid_q <= 1'b0;
      end
    end
  end

  // A write in the current cycle is the newest one for a read in that cycle.
  always_comb begin
    cmp_en    = armed_q && !frame_done && !frame_start;
    eff_valid = dma_wr_en || valid_q;
    eff_addr  = dma_wr_en ? dma_wr_addr : last_q;
  end
endmodule

// File: rtl/erod_cmp.sv
module erod_cmp
  import erod_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DROP_BITS = 2
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              cmp_en,
  input  logic              eff_valid,
  input  logic [ADDR_W-1:0] eff_addr,
  output logic              hit
);
  wide_addr_t rd_w, wr_w;

  always_comb begin
    rd_w = '0;
    wr_w = '0;
    rd_w[ADDR_W-1:0] = rd_addr;
    wr_w[ADDR_W-1:0] = eff_addr;
    hit = rd_en && cmp_en && eff_valid && same_word(rd_w, wr_w, DROP_BITS);
  end
endmodule

// File: rtl/erod_capture.sv
module erod_capture
  import erod_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              host_clr,
  input  logic [ADDR_W-1:0] eff_addr,
  output logic              fail_flag,
  output logic [7:0]        cap_lo,
  output logic [7:0]        cap_hi
);
  localparam int unsigned NBYTES = CAP_W / 8;

  logic             flag_q;
  logic [CAP_W-1:0] cap_q;
  logic [CAP_W-1:0] addr_ext;
  logic             load;
  logic [7:0]       bytes [NBYTES];

  always_comb begin
    addr_ext = '0;
    addr_ext[ADDR_W-1:0] = eff_addr;
    load = hit && (!flag_q || host_clr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cap_q  <= '0;
    end else if (load) begin
      flag_q <= 1'b1;
      cap_q  <= addr_ext;
    end else if (host_clr) begin
      flag_q <= 1'b0;
      cap_q  <= '0;
    end
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign bytes[g] = cap_byte(cap_q, g);
  end

  assign fail_flag = flag_q;
  assign cap_lo    = bytes[0];
  assign cap_hi    = bytes[1];
endmodule

// File: rtl/early_rx_overrun_det.sv
module early_rx_overrun_det #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DROP_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_done,
  input  logic              dma_wr_en,
  input  logic [ADDR_W-1:0] dma_wr_addr,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              host_clr,
  output logic              fail_flag,
  output logic [7:0]        cap_lo,
  output logic [7:0]        cap_hi
);
  logic              cmp_en;
  logic              eff_valid;
  logic [ADDR_W-1:0] eff_addr;
  logic              cmp_hit;

  erod_wr_track #(.ADDR_W(ADDR_W)) i_track (
    .clk, .rst_n, .frame_start, .frame_done, .dma_wr_en, .dma_wr_addr,
    .cmp_en, .eff_valid, .eff_addr
  );

  erod_cmp #(.ADDR_W(ADDR_W), .DROP_BITS(DROP_BITS)) i_cmp (
    .rd_en, .rd_addr, .cmp_en, .eff_valid, .eff_addr, .hit(cmp_hit)
  );

  erod_capture #(.ADDR_W(ADDR_W)) i_cap (
    .clk, .rst_n, .hit(cmp_hit), .host_clr, .eff_addr,
    .fail_flag, .cap_lo, .cap_hi
  );
endmodule

// File: rtl/erod_checker.sv
module erod_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic       frame_done,
  input logic       rd_en,
  input logic       host_clr,
  input logic       cmp_hit,
  input logic       fail_flag,
  input logic [7:0] cap_lo,
  input logic [7:0] cap_hi
);
  AST_HIT_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n) cmp_hit |-> rd_en); // R3
  AST_NO_HIT_DONE: assert property (@(posedge clk) disable iff (!rst_n) (frame_done || frame_start) |-> !cmp_hit); // R4
  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) cmp_hit |=> fail_flag); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (fail_flag && !host_clr) |=> fail_flag); // R7
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (fail_flag && !host_clr) |=> $stable({cap_hi, cap_lo})); // R7
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (host_clr && !cmp_hit) |=> (!fail_flag && cap_lo == 8'h00 && cap_hi == 8'h00)); // R8
  AST_CLR_LOSES: assert property (@(posedge clk) disable iff (!rst_n) (host_clr && cmp_hit) |=> fail_flag); // R9
  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(fail_flag) |-> $past(cmp_hit)); // R6
endmodule

bind early_rx_overrun_det erod_checker i_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_done(frame_done),
  .rd_en(rd_en), .host_clr(host_clr), .cmp_hit(cmp_hit),
  .fail_flag(fail_flag), .cap_lo(cap_lo), .cap_hi(cap_hi)
);

// File: tb/test_early_rx_overrun_det.sv
module test_early_rx_overrun_det;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_start = 1'b0, frame_done = 1'b0;
  logic          dma_wr_en = 1'b0, rd_en = 1'b0, host_clr = 1'b0;
  logic [AW-1:0] dma_wr_addr = '0, rd_addr = '0;
  logic          fail_flag;
  logic [7:0]    cap_lo, cap_hi;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  early_rx_overrun_det #(.ADDR_W(AW)) i_early_rx_overrun_det (
    .clk, .rst_n, .frame_start, .frame_done, .dma_wr_en, .dma_wr_addr,
    .rd_en, .rd_addr, .host_clr, .fail_flag, .cap_lo, .cap_hi
  );

  // One clock: inputs set before this call are seen at the edge, then dropped.
  task automatic cyc();
    @(posedge clk); #1;
    frame_start = 0; frame_done = 0; dma_wr_en = 0; rd_en = 0; host_clr = 0;
  endtask

  task automatic chk(input string req, input logic exp_f, input logic [15:0] exp_cap);
    n_checks++;
    if (fail_flag !== exp_f || {cap_hi, cap_lo} !== exp_cap) begin
      n_fail++;
      $display("FAIL %s: flag=%0b cap=%h expected flag=%0b cap=%h",
               req, fail_flag, {cap_hi, cap_lo}, exp_f, exp_cap);
    end
  endtask

  task automatic wr(input logic [15:0] a); dma_wr_en = 1; dma_wr_addr = a; cyc(); endtask
  task automatic rd(input logic [15:0] a); rd_en = 1; rd_addr = a; cyc(); endtask
  task automatic clr(); host_clr = 1; cyc(); endtask
  task automatic start(); frame_start = 1; cyc(); endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", 1'b0, 16'h0000);
    rst_n = 1;
    // R1: disarmed before any frame_start
    wr(16'h1230); rd(16'h1230);
    chk("R1 unarmed", 1'b0, 16'h0000);

    // R3 sweep: expected match computed as equal word index
    for (int ws = 0; ws < 16; ws++) begin
      for (int d = 0; d < 32; d++) begin
        logic [15:0] wa, ra;
        logic        m;
        wa = 16'h4A00 + 16'(ws);
        ra = 16'h49F8 + 16'(d);
        m  = (wa / 4) == (ra / 4);
        start(); wr(wa); rd(ra);
        chk("R3 word compare", m, m ? wa : 16'h0000);
        clr();
      end
    end

    // R3: high bits matter
    start(); wr(16'hC004); rd(16'h4004);
    chk("R3 high bit differs", 1'b0, 16'h0000);

    // R2: only newest write tracked
    start(); wr(16'h0100); wr(16'h0200); rd(16'h0100);
    chk("R2 older write ignored", 1'b0, 16'h0000);
    rd(16'h0202);
    chk("R2 newest write", 1'b1, 16'h0200);
    clr();
    chk("R8 clear", 1'b0, 16'h0000);
    // R2: same-cycle write bypass
    dma_wr_en = 1; dma_wr_addr = 16'h0300; rd_en = 1; rd_addr = 16'h0301; cyc();
    chk("R2 same-cycle write", 1'b1, 16'h0300);
    clr();

    // R6: byte split of capture
    start(); wr(16'hAB37); rd(16'hAB34);
    chk("R6 capture bytes", 1'b1, 16'hAB37);
    // R7: further match does not overwrite
    wr(16'h5510); rd(16'h5510);
    chk("R7 sticky no overwrite", 1'b1, 16'hAB37);
    repeat (3) cyc();
    chk("R7 hold", 1'b1, 16'hAB37);
    // R9: clear with match in same cycle
    host_clr = 1; rd_en = 1; rd_addr = 16'h5512; cyc();
    chk("R9 clear vs match", 1'b1, 16'h5510);
    clr();
    chk("R8 clear after R9", 1'b0, 16'h0000);

    // R4: frame_done same cycle as read
    start(); wr(16'h0800);
    frame_done = 1; rd_en = 1; rd_addr = 16'h0800; cyc();
    chk("R4 done same cycle", 1'b0, 16'h0000);
    rd(16'h0800);
    chk("R4 after done", 1'b0, 16'h0000);
    // R4: read in frame_start cycle
    start(); wr(16'h0900);
    frame_start = 1; rd_en = 1; rd_addr = 16'h0900; cyc();
    chk("R4 start cycle", 1'b0, 16'h0000);

    // R5: after frame_start, old address not valid
    start(); wr(16'h0A00); frame_done = 1; cyc();
    start(); rd(16'h0A00);
    chk("R5 invalid before first write", 1'b0, 16'h0000);
    wr(16'h0B00); rd(16'h0B03);
    chk("R5 first write arms", 1'b1, 16'h0B00);
    clr();
    // R5: write in frame_start cycle counts
    frame_start = 1; dma_wr_en = 1; dma_wr_addr = 16'h0C40; cyc();
    rd(16'h0C41);
    chk("R5 write in start cycle", 1'b1, 16'h0C40);
    clr();

    done = 1'b1;
  end

  initial begin
    int cnt = 0;
    while (!done && cnt < 100000) begin @(posedge clk); cnt++; end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule